// File: doc/BRIEF.md
# Prioritized Interrupt Source Arbiter

This block takes the seven event strobes of a two-wire serial bus controller and turns them into a single maskable interrupt line for a processor. The events are transmit ready, receive ready, register-access ready, no-acknowledge, arbitration lost, stop condition seen and addressed as target. Each event sets a sticky flag. A separate mask register decides which flags may raise the line. A fixed-priority encoder reports the most urgent pending, unmasked flag as a small source code, so interrupt software can branch on it directly.

Software reaches three registers through a simple strobe bus: address, read strobe, write strobe and write data, with the read data returned in the strobe cycle. Reading the source-code register is an acknowledge. The read returns the code that is currently posted and clears that flag at the same clock edge. The three ready flags are the exception and stay set. After that edge the next most urgent request is posted.

A two-state controller drives the interrupt line. In `ST_QUIET` no unmasked flag is pending and the line is low. In `ST_POSTED` a code is posted and the line is high. The transition `go_post` (QUIET to POSTED) is taken when, after an edge, some unmasked flag is pending. The transition `go_quiet` (POSTED to QUIET) is taken when none is left. A self-loop in POSTED re-posts the next code after an acknowledge.

Top module: `irq_source_arbiter`

## Requirements
- R1: Event input bits, and status bits 6..0, map as follows: bit0 arbitration lost, bit1 no-acknowledge, bit2 register-access ready, bit3 receive ready, bit4 transmit ready, bit5 stop seen, bit6 addressed as target. A high event bit sets its flag at the next edge, whatever the mask.
- R2: Address 0 reads the status flags, address 1 is the mask register and address 2 reads the source code in bits 2..0. Unused bits read 0. After reset all flags, the mask and the code are 0 and `irq_o` is low.
- R3: After every clock edge, `irq_o` is high exactly when some flag is set together with its mask bit.
- R4: The source code is the code of the most urgent unmasked pending flag, most urgent first: arbitration lost=1, no-acknowledge=2, register-access ready=3, receive ready=4, transmit ready=5, stop seen=6, addressed as target=7. Code 0 means none is pending.
- R5: A source-code read returns the code posted before the read. The code that follows the acknowledge is readable from the next cycle.
- R6: A source-code read clears the flag it reports when the code is 1, 2, 6 or 7.
- R7: A source-code read leaves flags 2, 3 and 4 (codes 3, 4, 5) set, so the same code is reported again. Writing 1 to such a status bit clears it.
- R8: Writing 1 to a status bit clears that flag. Writing 0 to a status bit has no effect, and writes to address 2 are ignored.
- R9: When an event sets a flag in the same cycle that a write-one or an acknowledge clears it, the flag ends up set.
- R10: A mask write takes effect at its own edge, so `irq_o` and the code follow it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 7 | Event strobes, one per source |
| bus_addr_i | input | AW (2) | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW (8) | Write data |
| bus_rdata_o | output | DW (8) | Read data, valid during the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two things can land on one flag in the same cycle. An event strobe can arrive together with a software clear, and that clear can be either a write-one to the status register or an acknowledging read of the source code. The bench provokes both cases. It drives the event bit and the bus strobe on the same falling edge, and then reads the status register back. The case passes only if the flag survived, and the acknowledging read must still have returned the code that was posted before it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NSRC = 7;
    localparam int CW   = $clog2(NSRC + 1);

    // register addresses
    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_SRC  = 2'd2;

    // flags that an acknowledge leaves alone: register-access, receive, transmit ready
    localparam logic [NSRC-1:0] READY_MASK = 7'b0011100;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_POSTED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_arb_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] w1c_i,
    input  logic [NSRC-1:0] ack_clr_i,
    output logic [NSRC-1:0] flags_d_o,
    output logic [NSRC-1:0] flags_q_o
);

    logic [NSRC-1:0] flags_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic clr;
        // acknowledge may not clear a ready flag; a set always beats a clear
        assign clr = w1c_i[i] | (ack_clr_i[i] & ~READY_MASK[i]);
        assign flags_d_o[i] = set_i[i] | (flags_q[i] & ~clr);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flags_q[i] <= 1'b0;
            else         flags_q[i] <= flags_d_o[i];
        end
    end

    assign flags_q_o = flags_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output logic [CW-1:0]   code_o,
    output logic            any_o
);

    always_comb begin
        code_o = '0;
        // scan from least urgent to most urgent so the lowest index wins
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = CW'(i + 1);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
    import irq_arb_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [AW-1:0]   addr_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NSRC-1:0] flags_q_i,
    input  logic [CW-1:0]   code_q_i,
    output logic [NSRC-1:0] mask_d_o,
    output logic [NSRC-1:0] mask_q_o,
    output logic [NSRC-1:0] w1c_o,
    output logic            ack_o,
    output logic [DW-1:0]   rdata_o
);

    logic [NSRC-1:0] mask_q;
    logic            hit_stat;
    logic            hit_mask;
    logic            hit_src;

    assign hit_stat = addr_i == AW'(ADDR_STAT);
    assign hit_mask = addr_i == AW'(ADDR_MASK);
    assign hit_src  = addr_i == AW'(ADDR_SRC);

    assign w1c_o    = (wr_i && hit_stat) ? wdata_i[NSRC-1:0] : '0;
    assign ack_o    = rd_i && hit_src;
    assign mask_d_o = (wr_i && hit_mask) ? wdata_i[NSRC-1:0] : mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q <= '0;
        else         mask_q <= mask_d_o;
    end

    assign mask_q_o = mask_q;

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (1'b1)
                hit_stat: rdata_o = DW'(flags_q_i);
                hit_mask: rdata_o = DW'(mask_q);
                hit_src:  rdata_o = DW'(code_q_i);
                default:  rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_source_arbiter.sv
module irq_source_arbiter
    import irq_arb_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] ev_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic            bus_rd_i,
    input  logic            bus_wr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            irq_o
);

    logic [NSRC-1:0] flags_d, flags_q;
    logic [NSRC-1:0] mask_d, mask_q;
    logic [NSRC-1:0] w1c;
    logic [NSRC-1:0] ack_clr;
    logic            ack;
    logic [CW-1:0]   code_d, code_q;
    logic            any_d;
    arb_state_e      state_q, state_d;

    irq_bus_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (bus_addr_i),
        .rd_i      (bus_rd_i),
        .wr_i      (bus_wr_i),
        .wdata_i   (bus_wdata_i),
        .flags_q_i (flags_q),
        .code_q_i  (code_q),
        .mask_d_o  (mask_d),
        .mask_q_o  (mask_q),
        .w1c_o     (w1c),
        .ack_o     (ack),
        .rdata_o   (bus_rdata_o)
    );

    // one-hot of the posted code, applied only on an acknowledge
    for (genvar i = 0; i < NSRC; i++) begin : g_ack
        assign ack_clr[i] = ack && (code_q == CW'(i + 1));
    end

    irq_flag_bank u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (ev_i),
        .w1c_i     (w1c),
        .ack_clr_i (ack_clr),
        .flags_d_o (flags_d),
        .flags_q_o (flags_q)
    );

    // arbitrate on the values the registers take at this edge
    irq_prio_enc u_enc (
        .req_i  (flags_d & mask_d),
        .code_o (code_d),
        .any_o  (any_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_d)  state_d = ST_POSTED;   // go_post
            ST_POSTED: if (!any_d) state_d = ST_QUIET;    // go_quiet
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_QUIET;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_POSTED);
    end

endmodule

// File: rtl/irq_source_arbiter_chk.sv
module irq_source_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] ev_i,
    input logic [AW-1:0]   bus_addr_i,
    input logic            bus_rd_i,
    input logic            bus_wr_i,
    input logic            irq_o,
    input logic [NSRC-1:0] flags_q,
    input logic [NSRC-1:0] mask_q,
    input logic [CW-1:0]   code_q
);

    logic            src_rd;
    logic            stat_wr;
    logic [NSRC-1:0] code_oh;

    assign src_rd  = bus_rd_i && (bus_addr_i == AW'(ADDR_SRC));
    assign stat_wr = bus_wr_i && (bus_addr_i == AW'(ADDR_STAT));
    assign code_oh = (code_q == '0) ? '0 : (NSRC'(1) << (code_q - CW'(1)));

    // R1
    ev_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ev_i) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

    // R3
    irq_matches_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (|(flags_q & mask_q)));

    // R4
    code_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_q != '0) == irq_o);

    // R6
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_rd && |(code_oh & ~READY_MASK & ~ev_i)) |=> ((flags_q & $past(code_oh)) == '0));

    // R7
    ready_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_rd |=> ((flags_q & $past(flags_q) & READY_MASK) == ($past(flags_q) & READY_MASK)));

    // R8
    flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!src_rd && !stat_wr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

bind irq_source_arbiter irq_source_arbiter_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_i),
    .bus_addr_i (bus_addr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_wr_i   (bus_wr_i),
    .irq_o      (irq_o),
    .flags_q    (flags_q),
    .mask_q     (mask_q),
    .code_q     (code_q)
);

// File: tb/irq_source_arbiter_tb_top.sv
module irq_source_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ev = '0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_source_arbiter dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ev_i        (ev),
        .bus_addr_i  (addr),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_SRC  = 2'd2;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e);
        ev = e;
        @(posedge clk); @(negedge clk);
        ev = '0;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input int exp);
        logic [7:0] d;
        bus_read(a, d);
        check(req, int'(d), exp);
    endtask

    task automatic t_reset();
        check("R2 irq after reset", int'(irq), 0);
        expect_reg("R2 status after reset", A_STAT, 0);
        expect_reg("R2 mask after reset", A_MASK, 0);
        expect_reg("R2 code after reset", A_SRC, 0);
    endtask

    task automatic t_masked_event();
        pulse(7'h02);
        expect_reg("R1 masked nack flag set", A_STAT, 8'h02);
        check("R3 irq low while masked", int'(irq), 0);
        expect_reg("R4 code 0 while masked", A_SRC, 0);
    endtask

    task automatic t_unmask();
        bus_write(A_MASK, 8'h7F);
        check("R10 irq after mask write", int'(irq), 1);
        expect_reg("R4 nack code", A_SRC, 2);
        check("R6 irq after nack ack", int'(irq), 0);
        expect_reg("R6 nack cleared", A_STAT, 0);
    endtask

    task automatic t_priority();
        pulse(7'h61);
        expect_reg("R4 arb lost first", A_SRC, 1);
        check("R3 irq stays with pending", int'(irq), 1);
        expect_reg("R5 next code after ack", A_SRC, 6);
        expect_reg("R6 stop then addressed", A_SRC, 7);
        expect_reg("R6 all cleared", A_SRC, 0);
        check("R3 irq low when empty", int'(irq), 0);
    endtask

    task automatic t_ready_flags();
        pulse(7'h1E);
        expect_reg("R4 nack over readies", A_SRC, 2);
        expect_reg("R4 reg-access ready", A_SRC, 3);
        expect_reg("R7 reg-access ready kept", A_SRC, 3);
        bus_write(A_STAT, 8'h04);
        expect_reg("R7 rx ready after w1c", A_SRC, 4);
        expect_reg("R7 readies still set", A_STAT, 8'h18);
        bus_write(A_STAT, 8'h18);
        expect_reg("R7 readies cleared by w1c", A_STAT, 0);
        check("R3 irq low after w1c", int'(irq), 0);
    endtask

    task automatic t_write_zero();
        pulse(7'h20);
        bus_write(A_STAT, 8'h00);
        expect_reg("R8 write 0 keeps flag", A_STAT, 8'h20);
        bus_write(A_SRC, 8'h00);
        expect_reg("R8 source write ignored", A_SRC, 6);
        expect_reg("R8 flag gone after ack", A_STAT, 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        // event and write-one on the same flag
        ev = 7'h20; addr = A_STAT; wdata = 8'h20; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        ev = '0; wr = 1'b0; wdata = '0;
        expect_reg("R9 set beats w1c", A_STAT, 8'h20);
        // event and acknowledge on the same flag
        ev = 7'h20; addr = A_SRC; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        ev = '0; rd = 1'b0;
        check("R5 ack returns old code", int'(d), 6);
        expect_reg("R9 set beats ack", A_STAT, 8'h20);
        bus_write(A_STAT, 8'h20);
        expect_reg("R8 w1c clears stop", A_STAT, 0);
    endtask

    task automatic t_preempt();
        pulse(7'h08);
        expect_reg("R4 rx ready code", A_SRC, 4);
        expect_reg("R7 rx ready repeats", A_SRC, 4);
        pulse(7'h01);
        expect_reg("R4 arb lost preempts", A_SRC, 1);
        expect_reg("R7 rx ready returns", A_SRC, 4);
        bus_write(A_STAT, 8'h08);
        expect_reg("R7 rx cleared", A_SRC, 0);
    endtask

    task automatic t_mask_live();
        pulse(7'h40);
        check("R3 irq for addressed", int'(irq), 1);
        bus_write(A_MASK, 8'h00);
        check("R10 irq drops with mask", int'(irq), 0);
        expect_reg("R10 code 0 when masked", A_SRC, 0);
        expect_reg("R1 flag held while masked", A_STAT, 8'h40);
        bus_write(A_MASK, 8'h40);
        check("R10 irq back on unmask", int'(irq), 1);
        expect_reg("R4 addressed code", A_SRC, 7);
        check("R6 irq low after ack", int'(irq), 0);
        expect_reg("R2 mask readback", A_MASK, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_event();
        t_unmask();
        t_priority();
        t_ready_flags();
        t_write_zero();
        t_same_cycle();
        t_preempt();
        t_mask_live();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule